// File: doc/BRIEF.md
# Weighted-Symmetric Decoder Adder

This block is a single-pass combinational adder for two operands and a carry-in. It does not feed each operand bit to the logic as true and complement lines. Instead, each pair of adjacent bit positions goes into a decoder that counts by arithmetic weight. The two operand bits of the upper position weigh 2 each, and the two of the lower position weigh 1 each. The decoder raises exactly one of seven lines, naming the weighted total from 0 to 6. Every adder function of those four bits is an OR of some of those seven lines: pair generate, strict and inclusive pair propagate, and both sum bits for either value of the incoming carry.

The lowest pair and the carry-in share a five-input decoder with eight lines (total 0 to 7). That decoder yields the two lowest sum bits and the carry into position 2 directly. The pairs above it are grouped into strings. The pair at positions 2 and 3 forms a string of its own. Each string above that holds `STR_PAIRS` pairs. Inside a string, the carry into every pair is a sum of products over the pair generate and propagate lines below it in the same string and the string's own incoming carry. The carry into a string comes from the string beneath it in the same way. A parameter chooses whether the lookahead uses strict or inclusive propagate; both give the same result.

Top module: `wsym_adder_top`

## Requirements
- R1: For every input, {carryOut, sum} equals opA + opB + carryIn as an unsigned (WIDTH+1)-bit value.
- R2: For pair i (bits 2i+1 and 2i, i >= 1), the decoder raises exactly one of 7 lines, whose index is v = 2*(opA[2i+1]+opB[2i+1]) + opA[2i] + opB[2i]. sum[2i+1:2i] equals (v + ci) mod 4, where ci is the carry into bit 2i.
- R3: The low decoder raises exactly one of 8 lines, whose index is u = 2*(opA[1]+opB[1]) + opA[0] + opB[0] + carryIn. sum[1:0] equals u mod 4, and the carry into bit 2 is 1 exactly when u >= 4.
- R4: Pair generate is the OR of lines 4, 5 and 6. Strict propagate is line 3 alone. The two are never both high.
- R5: A carry entering at bit 0 crosses every string boundary. For example, all-ones plus zero with carryIn=1 gives sum zero and carryOut 1, and (2^k - 1) + 1 carries exactly to bit k.
- R6: With PROP_MODE=1 (inclusive propagate, lines 3 to 6), the outputs equal those with PROP_MODE=0 for every input, and inclusive propagate equals generate OR strict propagate.
- R7: carryOut is bit WIDTH of the arithmetic sum, including the alternating operands 0xAAAA + 0x5555 with either carry-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First addend |
| opB | input | WIDTH | Second addend |
| carryIn | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| carryOut | output | 1 | Carry out of bit WIDTH-1 |

## Verification
The one-hot checks on the decoders assume that every operand bit and the carry-in hold a settled 0 or 1. A missing or unknown value would make a weighted count land on no line or on two. The bench drives only full two-valued vectors. It changes them away from the sampling point, so every immediate check sees settled inputs. An eight-bit copy is swept over all of its inputs. The sixteen-bit copies, one per propagate mode, get directed carry-chain patterns and a pseudo-random run.

// File: rtl/wsym_adder_pkg.sv
package wsym_adder_pkg;

  localparam int PAIR_LINES = 7;
  localparam int LOW_LINES  = 8;

  typedef logic [PAIR_LINES-1:0] pairCode_t;
  typedef logic [LOW_LINES-1:0]  lowCode_t;

  // Pair signals handed from the datapath to the lookahead control
  typedef struct packed {
    logic gen;
    logic strictProp;
    logic inclProp;
  } grpSig_t;

  // First pair index of the string that holds pair grp (pair 1 stands alone)
  function automatic int stringStart(input int grp, input int strPairs);
    if (grp <= 1) return grp;
    return 2 + ((grp - 2) / strPairs) * strPairs;
  endfunction

endpackage

// File: rtl/wsym_pair_dec.sv
module wsym_pair_dec
  import wsym_adder_pkg::*;
(
  input  logic      aHi,
  input  logic      bHi,
  input  logic      aLo,
  input  logic      bLo,
  output pairCode_t code
);

  // Symmetric counts of each weight class
  logic hi0, hi1, hi2, lo0, lo1, lo2;

  always_comb begin
    hi2 = aHi & bHi;
    hi1 = aHi ^ bHi;
    hi0 = ~(aHi | bHi);
    lo2 = aLo & bLo;
    lo1 = aLo ^ bLo;
    lo0 = ~(aLo | bLo);
    code[0] = hi0 & lo0;
    code[1] = hi0 & lo1;
    code[2] = (hi1 & lo0) | (hi0 & lo2);
    code[3] = hi1 & lo1;
    code[4] = (hi2 & lo0) | (hi1 & lo2);
    code[5] = hi2 & lo1;
    code[6] = hi2 & lo2;
  end

  always_comb begin
    a_r2_pair_onehot: assert ($countones(code) == 1)
      else $error("R2 pair decoder not one-hot: %b", code);
  end

endmodule

// File: rtl/wsym_low_dec.sv
module wsym_low_dec
  import wsym_adder_pkg::*;
(
  input  logic a1,
  input  logic b1,
  input  logic a0,
  input  logic b0,
  input  logic cin,
  output logic sumLo,
  output logic sumHi,
  output logic carryOut
);

  logic     hi0, hi1, hi2, lo0, lo1, lo2, lo3;
  lowCode_t code;

  always_comb begin
    hi2 = a1 & b1;
    hi1 = a1 ^ b1;
    hi0 = ~(a1 | b1);
    lo3 = a0 & b0 & cin;
    lo2 = (a0 & b0 & ~cin) | (a0 & ~b0 & cin) | (~a0 & b0 & cin);
    lo1 = (a0 & ~b0 & ~cin) | (~a0 & b0 & ~cin) | (~a0 & ~b0 & cin);
    lo0 = ~(a0 | b0 | cin);
    code[0] = hi0 & lo0;
    code[1] = hi0 & lo1;
    code[2] = (hi0 & lo2) | (hi1 & lo0);
    code[3] = (hi0 & lo3) | (hi1 & lo1);
    code[4] = (hi1 & lo2) | (hi2 & lo0);
    code[5] = (hi1 & lo3) | (hi2 & lo1);
    code[6] = hi2 & lo2;
    code[7] = hi2 & lo3;
  end

  assign sumLo    = code[1] | code[3] | code[5] | code[7];
  assign sumHi    = code[2] | code[3] | code[6] | code[7];
  assign carryOut = code[4] | code[5] | code[6] | code[7];

  always_comb begin
    a_r3_low_onehot: assert ($countones(code) == 1)
      else $error("R3 low decoder not one-hot: %b", code);
  end

endmodule

// File: rtl/wsym_datapath.sv
module wsym_datapath
  import wsym_adder_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int NG   = WIDTH / 2
) (
  input  logic               [WIDTH-1:0] opA,
  input  logic               [WIDTH-1:0] opB,
  input  logic                           carryIn,
  input  logic               [NG-1:1]    pairCarry,
  output grpSig_t            [NG-1:1]    grp,
  output logic                           lowCarry,
  output logic               [WIDTH-1:0] sum
);

  wsym_low_dec u_low (
    .a1      (opA[1]),
    .b1      (opB[1]),
    .a0      (opA[0]),
    .b0      (opB[0]),
    .cin     (carryIn),
    .sumLo   (sum[0]),
    .sumHi   (sum[1]),
    .carryOut(lowCarry)
  );

  for (genvar g = 1; g < NG; g++) begin : g_pair
    pairCode_t code;
    logic      ci;

    wsym_pair_dec u_dec (
      .aHi (opA[2*g+1]),
      .bHi (opB[2*g+1]),
      .aLo (opA[2*g]),
      .bLo (opB[2*g]),
      .code(code)
    );

    assign ci = pairCarry[g];

    assign grp[g].gen        = code[4] | code[5] | code[6];
    assign grp[g].strictProp = code[3];
    assign grp[g].inclProp   = code[3] | code[4] | code[5] | code[6];

    // value + carry: low bit odd total, high bit total in {2,3,6,7}
    assign sum[2*g]   = ci ? (code[0] | code[2] | code[4] | code[6])
                           : (code[1] | code[3] | code[5]);
    assign sum[2*g+1] = ci ? (code[1] | code[2] | code[5] | code[6])
                           : (code[2] | code[3] | code[6]);

    always_comb begin
      a_r4_gen_prop_excl: assert (!(grp[g].gen && grp[g].strictProp))
        else $error("R4 generate and strict propagate both high in pair %0d", g);
    end
  end

endmodule

// File: rtl/wsym_carry_ctl.sv
module wsym_carry_ctl
  import wsym_adder_pkg::*;
#(
  parameter int NG        = 8,
  parameter int STR_PAIRS = 2,
  parameter int PROP_MODE = 0
) (
  input  grpSig_t [NG-1:1] grp,
  input  logic             lowCarry,
  output logic    [NG:1]   pairCarry
);

  logic [NG-1:1] genVec;
  logic [NG-1:1] propVec;

  for (genvar g = 1; g < NG; g++) begin : g_sel
    assign genVec[g] = grp[g].gen;
    if (PROP_MODE == 0) begin : g_strict
      assign propVec[g] = grp[g].strictProp;
    end else begin : g_incl
      assign propVec[g] = grp[g].inclProp;
    end
  end

  // Sum-of-products lookahead from the base carry of each string
  always_comb begin
    logic [NG:1] cv;
    cv    = '0;
    cv[1] = lowCarry;
    for (int g = 2; g <= NG; g++) begin
      int   top;
      int   base;
      logic acc;
      logic prod;
      top  = g - 1;
      base = stringStart(top, STR_PAIRS);
      acc  = 1'b0;
      prod = 1'b1;
      for (int j = top; j >= base; j--) begin
        acc  = acc | (genVec[j] & prod);
        prod = prod & propVec[j];
      end
      cv[g] = acc | (prod & cv[base]);
    end
    pairCarry = cv;
  end

  always_comb begin
    for (int g = 1; g < NG; g++) begin
      a_r6_incl_equiv: assert (grp[g].inclProp == (grp[g].gen | grp[g].strictProp))
        else $error("R6 inclusive propagate mismatch in pair %0d", g);
    end
  end

endmodule

// File: rtl/wsym_adder_top.sv
module wsym_adder_top
  import wsym_adder_pkg::*;
#(
  parameter int WIDTH     = 16,
  parameter int STR_PAIRS = 2,
  parameter int PROP_MODE = 0
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut
);

  localparam int NG = WIDTH / 2;

  grpSig_t [NG-1:1] grp;
  logic    [NG:1]   pairCarry;
  logic             lowCarry;

  wsym_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .pairCarry(pairCarry[NG-1:1]),
    .grp      (grp),
    .lowCarry (lowCarry),
    .sum      (sum)
  );

  wsym_carry_ctl #(
    .NG       (NG),
    .STR_PAIRS(STR_PAIRS),
    .PROP_MODE(PROP_MODE)
  ) u_ctl (
    .grp      (grp),
    .lowCarry (lowCarry),
    .pairCarry(pairCarry)
  );

  assign carryOut = pairCarry[NG];

  always_comb begin
    a_r1_sum_exact: assert ({carryOut, sum} ==
        (WIDTH+1)'(opA) + (WIDTH+1)'(opB) + (WIDTH+1)'(carryIn))
      else $error("R1 sum mismatch");
  end

endmodule

// File: tb/tb_wsym_adder_top.sv
module tb_wsym_adder_top;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [15:0] a, b;
  logic        c;
  logic [15:0] sumS, sumI;
  logic        coS, coI;

  logic [7:0]  sa, sb;
  logic        sc;
  logic [7:0]  sumSm;
  logic        coSm;

  wsym_adder_top #(.WIDTH(16), .STR_PAIRS(2), .PROP_MODE(0)) dut (
    .opA(a), .opB(b), .carryIn(c), .sum(sumS), .carryOut(coS));

  wsym_adder_top #(.WIDTH(16), .STR_PAIRS(2), .PROP_MODE(1)) dutIncl (
    .opA(a), .opB(b), .carryIn(c), .sum(sumI), .carryOut(coI));

  wsym_adder_top #(.WIDTH(8), .STR_PAIRS(2), .PROP_MODE(0)) dutSmall (
    .opA(sa), .opB(sb), .carryIn(sc), .sum(sumSm), .carryOut(coSm));

  task automatic report(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s a=%h b=%h c=%0d actual=%0h expected=%0h", req, a, b, c, act, exp);
    end
  endtask

  task automatic run16(input logic [15:0] va, input logic [15:0] vb, input logic vc, input string tag);
    logic [16:0] full;
    @(negedge clk);
    a = va; b = vb; c = vc;
    @(posedge clk); #1;
    full = 17'(va) + 17'(vb) + 17'(vc);
    report({coS, sumS} == full, {"R1 ", tag}, longint'({coS, sumS}), longint'(full));
    report(coS == full[16], {"R7 ", tag}, longint'(coS), longint'(full[16]));
    report(sumS[1:0] == 2'((va[1:0] + vb[1:0] + 2'(vc)) & 2'd3), {"R3 ", tag},
           longint'(sumS[1:0]), longint'(full[1:0]));
    for (int i = 1; i < 8; i++) begin
      logic [16:0] m, lowPart;
      int v, ci, expPair;
      m       = (17'd1 << (2*i)) - 17'd1;
      lowPart = (17'(va) & m) + (17'(vb) & m) + 17'(vc);
      ci      = int'(lowPart[2*i]);
      v       = 2 * (int'(va[2*i+1]) + int'(vb[2*i+1])) + int'(va[2*i]) + int'(vb[2*i]);
      expPair = (v + ci) % 4;
      report(int'(sumS[2*i +: 2]) == expPair, {"R2 ", tag},
             longint'(sumS[2*i +: 2]), longint'(expPair));
    end
    report({coI, sumI} == {coS, sumS}, {"R6 ", tag}, longint'({coI, sumI}), longint'({coS, sumS}));
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired before completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    a = '0; b = '0; c = 1'b0;
    sa = '0; sb = '0; sc = 1'b0;

    // R1 quiet operands
    run16(16'h0000, 16'h0000, 1'b0, "zero");
    run16(16'h0000, 16'h0000, 1'b1, "cin only");
    // R5 carry through every string boundary
    run16(16'hFFFF, 16'h0000, 1'b1, "R5 full ripple");
    report(sumS == 16'h0000 && coS == 1'b1, "R5 ripple result", longint'({coS, sumS}), 64'h10000);
    for (int k = 1; k <= 16; k++) begin
      run16(16'((32'd1 << k) - 32'd1), 16'h0001, 1'b0, "R5 carry to bit k");
    end
    // R7 alternating operands
    run16(16'hAAAA, 16'h5555, 1'b0, "R7 alt");
    report(sumS == 16'hFFFF && coS == 1'b0, "R7 alt no carry", longint'({coS, sumS}), 64'hFFFF);
    run16(16'hAAAA, 16'h5555, 1'b1, "R7 alt cin");
    report(sumS == 16'h0000 && coS == 1'b1, "R7 alt carry out", longint'({coS, sumS}), 64'h10000);
    run16(16'hFFFF, 16'hFFFF, 1'b1, "R4 all generate");
    run16(16'h5555, 16'h5555, 1'b1, "R4 value 2 pairs");
    run16(16'h3333, 16'h3333, 1'b0, "R4 value 6 pairs");

    // R2 R6 pseudo-random run
    lfsr = 32'hACE1_1234;
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      run16(lfsr[15:0], lfsr[31:16] ^ 16'(n), lfsr[7], "random");
    end

    // R1 R3 exhaustive sweep of the eight-bit configuration
    for (int v = 0; v < (1 << 17); v++) begin
      logic [8:0] full;
      @(negedge clk);
      sa = v[7:0]; sb = v[15:8]; sc = v[16];
      @(posedge clk); #1;
      full = 9'(v[7:0]) + 9'(v[15:8]) + 9'(v[16]);
      checks++;
      if ({coSm, sumSm} != full) begin
        failures++;
        $display("FAIL R1 small a=%h b=%h c=%0d actual=%h expected=%h",
                 v[7:0], v[15:8], v[16], {coSm, sumSm}, full);
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule